// File: doc/BRIEF.md
# Table-Driven Zero-Suppression Filter

This block reduces one captured event of front-end samples to the channels worth keeping. Each of the 128 channels carries three 12-bit time samples. A host first loads two small tables: a per-channel threshold and, for each channel, up to four programmable companion channels. Any channel can be named as a companion. The event is then written into the block's event store, and a start pulse launches processing.

Processing runs as a state machine with named states. IDLE waits for start. THRESH scans the channels and marks each one whose samples pass its own threshold. EXPAND walks the companion table of every marked channel and adds those companions to the keep mask. HEADER emits one header word with the record count and the truncation flag. EMIT scans the keep mask in ascending channel order and emits one record per kept channel. DONE raises the completion pulse and returns to IDLE.

The transitions are as follows. IDLE goes to THRESH on start. THRESH goes to EXPAND after the last channel, or straight to HEADER in bypass. EXPAND goes to HEADER after the last slot of the last channel. HEADER always goes to EMIT. EMIT goes to DONE after the last channel. DONE goes to IDLE. The output size is capped by a byte budget; records beyond the cap are dropped and a flag is raised. A bypass control emits every channel unsuppressed.

Top module: `zs_filter`

## Requirements
- R1: After reset the block is idle (`busy`=0), `out_valid`=0, `done`=0 and `trunc`=0, and every companion entry is invalid.
- R2: A channel is a hit when any of its three samples is strictly greater than that channel's own threshold (a sample equal to the threshold does not pass). Every emitted record carries all three samples of its channel.
- R3: For every hit channel, each valid companion entry marks its channel as kept, whatever that channel's samples are. Companion entries are written with `cfg_tbl`=1: bit 7 of `cfg_wdata` is the valid bit and bits 6:0 hold the channel. Expansion starts only from hits and does not chain through channels that were kept only as companions.
- R4: Records come out in strictly ascending channel order, and a channel appears at most once, even when it is reached several times.
- R5: Each run emits exactly one header word (`out_hdr`=1) before any record. In the header, bits 7:0 hold the number of records that follow and bit 8 holds the truncation flag; all other bits are 0.
- R6: A record (`out_hdr`=0) has the channel in bits 42:36, sample 2 in bits 35:24, sample 1 in bits 23:12 and sample 0 in bits 11:0. Samples are written the same way on `ev_wdata`.
- R7: Outside bypass, at most 64 records are emitted (a 512-byte budget at 8 bytes per record). When more channels are kept, the lowest 64 kept channels are emitted, the header count is 64, and bit 8 of the header and `trunc` are 1.
- R8: With `bypass`=1 at start, all 128 channels are emitted in order with their samples. Thresholds and the cap are not applied, and `trunc` is 0.
- R9: A start pulse while `busy`=1 is ignored. `done` is a single-cycle pulse after the last word of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | Table select: 0 threshold, 1 companion |
| cfg_ch | input | 7 | Channel whose entry is written |
| cfg_slot | input | 2 | Companion slot (companion table only) |
| cfg_wdata | input | 12 | Threshold value, or {valid, channel} in bits 7:0 |
| ev_we | input | 1 | Event store write strobe |
| ev_ch | input | 7 | Channel written into the event store |
| ev_wdata | input | 36 | Three samples {s2, s1, s0} |
| start | input | 1 | Start pulse for one run |
| bypass | input | 1 | Sampled at start: emit the full event |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | Output word valid this cycle |
| out_hdr | output | 1 | Output word is the header |
| out_data | output | 43 | Header or record word |
| done | output | 1 | One-cycle end-of-run pulse |
| trunc | output | 1 | Last run was truncated (held until the next start) |

## Verification
The main function is exercised with several event patterns. An isolated-hit event places the passing sample in each of the three sample positions and adds an exactly-at-threshold channel, which separates a strict compare from an inclusive one and shows whether all samples are checked. A companion event uses wrap-around, self-referencing, duplicate and chained entries, which tells table-driven expansion apart from adjacency, from chaining and from duplicate output. An all-hit event exposes the cap and the choice of the lowest channels, and the same event in bypass checks that neither the thresholds nor the cap apply. An empty event and a start pulse given mid-run cover the header-only case and the busy guard.

// File: rtl/zs_pkg.sv
package zs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_THRESH,
        S_EXPAND,
        S_HEADER,
        S_EMIT,
        S_DONE
    } zs_state_e;

    // number of ones in a vector, used for the header count
    function automatic logic [15:0] count_ones(input logic [255:0] v, input int n);
        logic [15:0] c;
        c = '0;
        for (int i = 0; i < n; i++) begin
            c = c + 16'(v[i]);
        end
        return c;
    endfunction
endpackage

// File: rtl/zs_tables.sv
module zs_tables #(
    parameter int NCH = 128,
    parameter int SW  = 12,
    parameter int NNB = 4,
    localparam int CHW = $clog2(NCH),
    localparam int SLW = (NNB > 1) ? $clog2(NNB) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           thr_we,
    input  logic [CHW-1:0] thr_waddr,
    input  logic [SW-1:0]  thr_wdata,
    input  logic           nbr_we,
    input  logic [CHW-1:0] nbr_waddr,
    input  logic [SLW-1:0] nbr_wslot,
    input  logic           nbr_wvalid,
    input  logic [CHW-1:0] nbr_wch,
    input  logic [CHW-1:0] rd_ch,
    input  logic [SLW-1:0] rd_slot,
    output logic [SW-1:0]  thr_rdata,
    output logic           nbr_rvalid,
    output logic [CHW-1:0] nbr_rch
);
    localparam int NENT = NCH * NNB;

    logic [SW-1:0]  thr_mem [NCH];
    logic [CHW-1:0] nbr_mem [NENT];
    logic [NENT-1:0] nbr_vld_q;

    logic [$clog2(NENT)-1:0] wr_ent;
    logic [$clog2(NENT)-1:0] rd_ent;

    assign wr_ent = $clog2(NENT)'(nbr_waddr) * $clog2(NENT)'(NNB) + $clog2(NENT)'(nbr_wslot);
    assign rd_ent = $clog2(NENT)'(rd_ch) * $clog2(NENT)'(NNB) + $clog2(NENT)'(rd_slot);

    always_ff @(posedge clk) begin
        if (thr_we) begin
            thr_mem[thr_waddr] <= thr_wdata;
        end
        if (nbr_we) begin
            nbr_mem[wr_ent] <= nbr_wch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbr_vld_q <= '0;
        end else if (nbr_we) begin
            nbr_vld_q[wr_ent] <= nbr_wvalid;
        end
    end

    assign thr_rdata  = thr_mem[rd_ch];
    assign nbr_rvalid = nbr_vld_q[rd_ent];
    assign nbr_rch    = nbr_mem[rd_ent];

    // R1: companion entries are invalid straight after reset
    a_r1_nbr_clear: assert property (@(posedge clk)
        $fell(rst_n) |=> (nbr_vld_q == '0));
endmodule

// File: rtl/zs_event_store.sv
module zs_event_store #(
    parameter int NCH = 128,
    parameter int SW  = 12,
    parameter int NS  = 3,
    localparam int CHW = $clog2(NCH),
    localparam int EW  = NS * SW
) (
    input  logic           clk,
    input  logic           we,
    input  logic [CHW-1:0] waddr,
    input  logic [EW-1:0]  wdata,
    input  logic [CHW-1:0] raddr,
    output logic [EW-1:0]  rdata
);
    logic [EW-1:0] mem [NCH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/zs_hit_cmp.sv
module zs_hit_cmp #(
    parameter int SW = 12,
    parameter int NS = 3,
    localparam int EW = NS * SW
) (
    input  logic [EW-1:0] samples,
    input  logic [SW-1:0] thr,
    output logic          hit
);
    logic [NS-1:0] above;

    for (genvar s = 0; s < NS; s++) begin : g_cmp
        assign above[s] = samples[s*SW +: SW] > thr;
    end

    assign hit = |above;
endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
    import zs_pkg::*;
#(
    parameter int NCH     = 128,
    parameter int SW      = 12,
    parameter int NS      = 3,
    parameter int NNB     = 4,
    parameter int MAX_REC = 64,
    localparam int CHW  = $clog2(NCH),
    localparam int SLW  = (NNB > 1) ? $clog2(NNB) : 1,
    localparam int EW   = NS * SW,
    localparam int OW   = CHW + EW,
    localparam int CNTW = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           bypass,
    output logic [CHW-1:0] scan_ch,
    output logic [SLW-1:0] scan_slot,
    input  logic           hit_in,
    input  logic           nbr_valid,
    input  logic [CHW-1:0] nbr_ch,
    input  logic [EW-1:0]  ev_data,
    output logic           busy,
    output logic           out_valid,
    output logic           out_hdr,
    output logic [OW-1:0]  out_data,
    output logic           done,
    output logic           trunc
);
    zs_state_e state_q, state_d;

    logic [CHW-1:0]  idx_q;
    logic [SLW-1:0]  slot_q;
    logic [NCH-1:0]  hit_q;
    logic [NCH-1:0]  keep_q;
    logic            bypass_q;
    logic [CNTW-1:0] emit_cnt_q;
    logic            trunc_q;
    logic            out_valid_q, out_hdr_q, done_q;
    logic [OW-1:0]   out_data_q;

    logic            last_ch;
    logic            last_slot;
    logic [CNTW-1:0] kept_total;
    logic            over_cap;
    logic            room;

    assign last_ch    = (idx_q == CHW'(NCH - 1));
    assign last_slot  = (slot_q == SLW'(NNB - 1));
    assign kept_total = CNTW'(count_ones(256'(keep_q), NCH));
    assign over_cap   = !bypass_q && (kept_total > CNTW'(MAX_REC));
    assign room       = bypass_q || (emit_cnt_q < CNTW'(MAX_REC));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_THRESH;
            S_THRESH: if (last_ch) state_d = bypass_q ? S_HEADER : S_EXPAND;
            S_EXPAND: if (last_ch && last_slot) state_d = S_HEADER;
            S_HEADER: state_d = S_EMIT;
            S_EMIT:   if (last_ch) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            slot_q      <= '0;
            hit_q       <= '0;
            keep_q      <= '0;
            bypass_q    <= 1'b0;
            emit_cnt_q  <= '0;
            trunc_q     <= 1'b0;
            out_valid_q <= 1'b0;
            out_hdr_q   <= 1'b0;
            out_data_q  <= '0;
            done_q      <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            out_hdr_q   <= 1'b0;
            done_q      <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        bypass_q   <= bypass;
                        trunc_q    <= 1'b0;
                        idx_q      <= '0;
                        slot_q     <= '0;
                        hit_q      <= '0;
                        keep_q     <= '0;
                        emit_cnt_q <= '0;
                    end
                end
                S_THRESH: begin
                    hit_q[idx_q]  <= hit_in;
                    keep_q[idx_q] <= hit_in | bypass_q;
                    idx_q         <= last_ch ? '0 : idx_q + 1'b1;
                end
                S_EXPAND: begin
                    if (hit_q[idx_q] && nbr_valid) begin
                        keep_q[nbr_ch] <= 1'b1;
                    end
                    slot_q <= last_slot ? '0 : slot_q + 1'b1;
                    if (last_slot) begin
                        idx_q <= last_ch ? '0 : idx_q + 1'b1;
                    end
                end
                S_HEADER: begin
                    out_valid_q              <= 1'b1;
                    out_hdr_q                <= 1'b1;
                    out_data_q               <= '0;
                    out_data_q[CNTW-1:0]     <= over_cap ? CNTW'(MAX_REC) : kept_total;
                    out_data_q[CNTW]         <= over_cap;
                    trunc_q                  <= over_cap;
                    emit_cnt_q               <= '0;
                    idx_q                    <= '0;
                end
                S_EMIT: begin
                    if (keep_q[idx_q] && room) begin
                        out_valid_q <= 1'b1;
                        out_data_q  <= {idx_q, ev_data};
                        emit_cnt_q  <= emit_cnt_q + 1'b1;
                    end
                    idx_q <= last_ch ? '0 : idx_q + 1'b1;
                end
                S_DONE: begin
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign scan_ch   = idx_q;
    assign scan_slot = slot_q;
    assign busy      = (state_q != S_IDLE);
    assign out_valid = out_valid_q;
    assign out_hdr   = out_hdr_q;
    assign out_data  = out_data_q;
    assign done      = done_q;
    assign trunc     = trunc_q;

    // observation state for the ordering and header checks
    logic           seen_rec_q, seen_hdr_q;
    logic [CHW-1:0] prev_ch_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_rec_q <= 1'b0;
            seen_hdr_q <= 1'b0;
            prev_ch_q  <= '0;
        end else if (done_q) begin
            seen_rec_q <= 1'b0;
            seen_hdr_q <= 1'b0;
        end else if (out_valid_q && out_hdr_q) begin
            seen_hdr_q <= 1'b1;
            seen_rec_q <= 1'b0;
        end else if (out_valid_q) begin
            seen_rec_q <= 1'b1;
            prev_ch_q  <= out_data_q[OW-1 -: CHW];
        end
    end

    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hdr && seen_rec_q) |-> (out_data[OW-1 -: CHW] > prev_ch_q));
    a_r5_hdr_first: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hdr) |-> seen_hdr_q);
    a_r5_one_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hdr) |-> !seen_hdr_q);
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hdr && !bypass_q) |-> (emit_cnt_q <= CNTW'(MAX_REC)));
    a_r8_bypass_untruncated: assert property (@(posedge clk) disable iff (!rst_n)
        trunc |-> !bypass_q);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);
endmodule

// File: rtl/zs_filter.sv
module zs_filter #(
    parameter int NCH       = 128,
    parameter int SW        = 12,
    parameter int NS        = 3,
    parameter int NNB       = 4,
    parameter int CAP_BYTES = 512,
    parameter int REC_BYTES = 8,
    localparam int CHW     = $clog2(NCH),
    localparam int SLW     = (NNB > 1) ? $clog2(NNB) : 1,
    localparam int EW      = NS * SW,
    localparam int OW      = CHW + EW,
    localparam int MAX_REC = CAP_BYTES / REC_BYTES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic           cfg_tbl,
    input  logic [CHW-1:0] cfg_ch,
    input  logic [SLW-1:0] cfg_slot,
    input  logic [SW-1:0]  cfg_wdata,
    input  logic           ev_we,
    input  logic [CHW-1:0] ev_ch,
    input  logic [EW-1:0]  ev_wdata,
    input  logic           start,
    input  logic           bypass,
    output logic           busy,
    output logic           out_valid,
    output logic           out_hdr,
    output logic [OW-1:0]  out_data,
    output logic           done,
    output logic           trunc
);
    logic [CHW-1:0] scan_ch;
    logic [SLW-1:0] scan_slot;
    logic [SW-1:0]  thr_rdata;
    logic           nbr_rvalid;
    logic [CHW-1:0] nbr_rch;
    logic [EW-1:0]  ev_rdata;
    logic           hit;

    zs_tables #(.NCH(NCH), .SW(SW), .NNB(NNB)) u_tables (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_we    (cfg_we && !cfg_tbl),
        .thr_waddr (cfg_ch),
        .thr_wdata (cfg_wdata),
        .nbr_we    (cfg_we && cfg_tbl),
        .nbr_waddr (cfg_ch),
        .nbr_wslot (cfg_slot),
        .nbr_wvalid(cfg_wdata[CHW]),
        .nbr_wch   (cfg_wdata[CHW-1:0]),
        .rd_ch     (scan_ch),
        .rd_slot   (scan_slot),
        .thr_rdata (thr_rdata),
        .nbr_rvalid(nbr_rvalid),
        .nbr_rch   (nbr_rch)
    );

    zs_event_store #(.NCH(NCH), .SW(SW), .NS(NS)) u_store (
        .clk  (clk),
        .we   (ev_we),
        .waddr(ev_ch),
        .wdata(ev_wdata),
        .raddr(scan_ch),
        .rdata(ev_rdata)
    );

    zs_hit_cmp #(.SW(SW), .NS(NS)) u_cmp (
        .samples(ev_rdata),
        .thr    (thr_rdata),
        .hit    (hit)
    );

    zs_ctrl #(.NCH(NCH), .SW(SW), .NS(NS), .NNB(NNB), .MAX_REC(MAX_REC)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bypass   (bypass),
        .scan_ch  (scan_ch),
        .scan_slot(scan_slot),
        .hit_in   (hit),
        .nbr_valid(nbr_rvalid),
        .nbr_ch   (nbr_rch),
        .ev_data  (ev_rdata),
        .busy     (busy),
        .out_valid(out_valid),
        .out_hdr  (out_hdr),
        .out_data (out_data),
        .done     (done),
        .trunc    (trunc)
    );
endmodule

// File: tb/zs_filter_tb.sv
module zs_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 128;
    localparam int MAXR = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_tbl = 1'b0;
    logic [6:0]  cfg_ch = '0;
    logic [1:0]  cfg_slot = '0;
    logic [11:0] cfg_wdata = '0;
    logic        ev_we = 1'b0;
    logic [6:0]  ev_ch = '0;
    logic [35:0] ev_wdata = '0;
    logic        start = 1'b0, bypass = 1'b0;
    logic        busy, out_valid, out_hdr, done, trunc;
    logic [42:0] out_data;

    zs_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_ch(cfg_ch), .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata),
        .ev_we(ev_we), .ev_ch(ev_ch), .ev_wdata(ev_wdata),
        .start(start), .bypass(bypass), .busy(busy), .out_valid(out_valid),
        .out_hdr(out_hdr), .out_data(out_data), .done(done), .trunc(trunc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;

    // bench copies of the tables and event
    logic [11:0] b_thr [NCH];
    logic        b_nv  [NCH][4];
    logic [6:0]  b_nc  [NCH][4];
    logic [11:0] b_ev  [NCH][3];

    // collected output
    logic [42:0] got_rec [NCH];
    int          got_n = 0;
    int          hdr_n = 0;
    logic [42:0] got_hdr = '0;
    int          done_n = 0;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (out_hdr) begin
                hdr_n++;
                got_hdr = out_data;
            end else if (got_n < NCH) begin
                got_rec[got_n] = out_data;
                got_n++;
            end
        end
        if (rst_n && done) done_n++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_thr(input int c, input int v);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = 0; cfg_ch = 7'(c); cfg_wdata = 12'(v);
        b_thr[c] = 12'(v);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_nbr(input int c, input int s, input bit v, input int n);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = 1; cfg_ch = 7'(c); cfg_slot = 2'(s);
        cfg_wdata = {4'b0, v, 7'(n)};
        b_nv[c][s] = v; b_nc[c][s] = 7'(n);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_ev(input int c, input int s0, input int s1, input int s2);
        @(negedge clk);
        ev_we = 1; ev_ch = 7'(c); ev_wdata = {12'(s2), 12'(s1), 12'(s0)};
        b_ev[c][0] = 12'(s0); b_ev[c][1] = 12'(s1); b_ev[c][2] = 12'(s2);
        @(negedge clk);
        ev_we = 0;
    endtask

    task automatic fill(input int thr, input int smp);
        for (int c = 0; c < NCH; c++) begin
            set_thr(c, thr);
            set_ev(c, smp, smp, smp);
        end
    endtask

    task automatic clear_nbr();
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++)
                if (b_nv[c][s]) set_nbr(c, s, 0, 0);
    endtask

    task automatic run(input bit byp, input bit restart_mid);
        int t;
        got_n = 0; hdr_n = 0; done_n = 0;
        @(negedge clk);
        start = 1; bypass = byp;
        @(negedge clk);
        start = 0; bypass = 0;
        if (restart_mid) begin
            repeat (20) @(negedge clk);
            start = 1; bypass = 1;
            @(negedge clk);
            start = 0; bypass = 0;
        end
        t = 0;
        while (done_n == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (done_n == 0) check(0, "R9 run timeout", 0, 1);
        repeat (3) @(negedge clk);
    endtask

    // expected result from the requirements, compared with the collected output
    task automatic compare(input bit byp, input string tag);
        bit hit [NCH];
        bit keep [NCH];
        int kept, nexp, k;
        bit tr;
        for (int c = 0; c < NCH; c++) begin
            hit[c] = (b_ev[c][0] > b_thr[c]) || (b_ev[c][1] > b_thr[c]) || (b_ev[c][2] > b_thr[c]);
            keep[c] = hit[c] || byp;
        end
        if (!byp)
            for (int c = 0; c < NCH; c++)
                if (hit[c])
                    for (int s = 0; s < 4; s++)
                        if (b_nv[c][s]) keep[b_nc[c][s]] = 1;
        kept = 0;
        for (int c = 0; c < NCH; c++) if (keep[c]) kept++;
        tr = !byp && kept > MAXR;
        nexp = tr ? MAXR : kept;
        check(hdr_n == 1, {tag, " R5 header count"}, hdr_n, 1);
        check(got_hdr == 43'({tr, 8'(nexp)}), {tag, " R5/R7 header word"}, got_hdr, {tr, 8'(nexp)});
        check(trunc == tr, {tag, " R7/R8 trunc flag"}, trunc, tr);
        check(got_n == nexp, {tag, " R2/R3/R7 record count"}, got_n, nexp);
        check(done_n == 1, {tag, " R9 single done"}, done_n, 1);
        k = 0;
        for (int c = 0; c < NCH && k < nexp && k < got_n; c++) begin
            if (keep[c]) begin
                logic [42:0] e;
                e = {7'(c), b_ev[c][2], b_ev[c][1], b_ev[c][0]};
                check(got_rec[k] == e, {tag, " R4/R6 record"}, got_rec[k], e);
                k++;
            end
        end
    endtask

    task automatic t_reset();
        check(busy == 0, "R1 busy", busy, 0);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(done == 0, "R1 done", done, 0);
        check(trunc == 0, "R1 trunc", trunc, 0);
    endtask

    task automatic t_threshold();
        fill(100, 50);
        set_ev(5, 101, 0, 0);     // sample 0 passes
        set_ev(40, 0, 101, 0);    // sample 1 passes
        set_ev(77, 0, 0, 4095);   // sample 2 passes
        set_ev(90, 100, 100, 100);// equal: not a hit (R2)
        set_thr(120, 10);         // own threshold lower: hit on 50
        run(0, 0);
        compare(0, "thr");
    endtask

    task automatic t_neighbours();
        fill(100, 50);
        set_ev(10, 200, 0, 0);
        set_ev(3, 200, 0, 0);
        set_nbr(10, 0, 1, 3);     // duplicate with a hit
        set_nbr(10, 1, 1, 127);
        set_nbr(10, 2, 1, 10);    // self
        set_nbr(10, 3, 1, 50);
        set_nbr(50, 0, 1, 60);    // not chained (R3)
        set_nbr(3, 1, 0, 99);     // invalid slot
        set_nbr(127, 0, 1, 0);    // 127 kept only as companion
        run(0, 0);
        compare(0, "nbr");
        clear_nbr();
    endtask

    task automatic t_cap();
        fill(0, 1);
        run(0, 0);
        compare(0, "cap");
    endtask

    task automatic t_bypass();
        fill(4095, 7);
        set_ev(9, 1, 2, 3);
        run(1, 0);
        compare(1, "bypass");
    endtask

    task automatic t_empty_and_busy();
        fill(200, 5);
        run(0, 0);
        compare(0, "empty");
        set_ev(33, 300, 0, 0);
        run(0, 1);               // second start while busy ignored (R9)
        compare(0, "busy");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < 4; s++) begin
                b_nv[c][s] = 0; b_nc[c][s] = '0;
            end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_neighbours();
        t_cap();
        t_bypass();
        t_empty_and_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule